// File: doc/BRIEF.md
# Timeslot Signaling Channel Memory Controller

The block keeps a control memory with one entry per timeslot of a multiplexed serial frame. Each entry holds a 4-bit channel code and an 8-bit data field. Timeslots are grouped into pairs. The even entry of a pair holds a signaling or command/indication value. The odd timeslot of that pair sends the value in every frame, for as long as the even entry's code field is non-zero.

A host writes the value into a staging register and writes the target timeslot and the value width into an address register. It then writes a command word. One command kind loads a new channel code and the masked staged value together. The other kind refreshes only the data field. The command captures all of its operands when it is written. The memory update is held back until the next frame boundary, so a frame never carries a half-applied change.

A frame engine steps through the timeslots on a tick input. For each slot it presents the value to be sent, or an idle pattern when nothing is to be sent.

Top module: `sigch_ctrl_mem`

## Requirements
- R1: After reset, busy and cmd_err are 0, ts_num is 0, and every entry has code 0 and data 0. As a result, tx_active is 0 and tx_data is 8'hFF in every timeslot.
- R2: ts_num advances by one on each clock edge where ts_tick is 1, wrapping from 31 to 0. It holds its value when ts_tick is 0.
- R3: While ts_num is odd and entry ts_num-1 has a non-zero code, tx_active is 1 and tx_data equals that entry's data. In every other case tx_active is 0 and tx_data is 8'hFF.
- R4: Host writes use hw_sel as follows:
  - hw_sel 0 loads the staged value from hw_wdata[7:0].
  - hw_sel 1 loads the target timeslot from hw_wdata[4:0] and the width select from hw_wdata[6:5].
  - hw_sel 2 is a command: hw_wdata[3:0] is the channel code, hw_wdata[7:4] is the operation, and hw_wdata[8] is the read/write select.
- R5: A command with operation 111x (bit 4 ignored) and select 0 stores the channel code and the masked staged value into the target entry.
- R6: A command with operation 1001 and select 0 stores only the masked staged value and leaves the code field unchanged.
- R7: Width select 00 keeps staged bits [3:0], 01 keeps bits [5:0], and 10 or 11 keeps all 8 bits. Bits above the kept width are stored as 0.
- R8: A command with select 1, or with any operation other than 111x and 1001, changes neither the memory, busy nor cmd_err.
- R9: busy is 1 from the cycle after an accepted command until the commit edge, which is the edge where ts_tick is 1 while ts_num is 31. The new entry contents appear from timeslot 0 of the following frame and never earlier.
- R10: A command written while busy is 1 is ignored.
- R11: A valid command whose target timeslot is odd is rejected: cmd_err becomes 1 on the next cycle and busy stays 0. An accepted command clears cmd_err.
- R12: The staged value, target, width and code are captured when the command is accepted. Host register writes made after that do not change the pending update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_en | input | 1 | Host register write strobe |
| hw_sel | input | 2 | Host register select |
| hw_wdata | input | 9 | Host write data |
| ts_tick | input | 1 | Advance to the next timeslot |
| ts_num | output | 5 | Current timeslot number |
| tx_active | output | 1 | Current timeslot carries a stored value |
| tx_data | output | 8 | Value for the current timeslot, idle 8'hFF |
| busy | output | 1 | A transfer is waiting for the frame boundary |
| cmd_err | output | 1 | Last valid command was rejected for an odd target |

## Verification
A corrupted entry shows at the ports only when the frame engine reaches the odd timeslot of that pair, so up to one full frame of ticks can pass before it is seen. A wrongly held or lost pending transfer shows as a busy level that differs from the expected one in the very next cycle. A commit at the wrong edge shows as a changed tx_data inside a frame. The bench tracks busy, the error flag, the timeslot and the sent value against a behavioural model on every clock. It also places directed checks in the odd slots of the pairs it programs.

// File: rtl/sigch_pkg.sv
// Shared types for the signaling channel memory controller.
// Assumes a 4-bit operation field in the host command word.
package sigch_pkg;

    typedef enum logic [1:0] {
        XF_NONE = 2'd0,
        XF_FULL = 2'd1,
        XF_DATA = 2'd2
    } xfer_kind_e;

    localparam logic [1:0] WSEL_4 = 2'b00;
    localparam logic [1:0] WSEL_6 = 2'b01;

    // Map an operation code onto the transfer it requests
    function automatic xfer_kind_e decode_op(input logic [3:0] op);
        if (op[3:1] == 3'b111) begin
            return XF_FULL;
        end else if (op == 4'b1001) begin
            return XF_DATA;
        end
        return XF_NONE;
    endfunction

endpackage

// File: rtl/sigch_host_regs.sv
// Host register file: staging value, target/width and command decode.
// Assumes BUS_W >= CW+5 and BUS_W > DW, AW+1.
module sigch_host_regs
    import sigch_pkg::*;
#(
    parameter int AW    = 5,
    parameter int DW    = 8,
    parameter int CW    = 4,
    parameter int BUS_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_en,
    input  logic [1:0]       hw_sel,
    input  logic [BUS_W-1:0] hw_wdata,
    output logic [DW-1:0]    stg_q,
    output logic [AW-1:0]    adr_q,
    output logic [1:0]       wsel_q,
    output logic             cmd_stb,
    output xfer_kind_e       cmd_kind,
    output logic [CW-1:0]    cmd_code
);
    localparam int OP_LSB  = CW;
    localparam int RWS_BIT = CW + 4;

    // Load the staging and target registers on host writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q  <= '0;
            adr_q  <= '0;
            wsel_q <= '0;
        end else if (hw_en) begin
            if (hw_sel == 2'd0) begin
                stg_q <= hw_wdata[DW-1:0];
            end else if (hw_sel == 2'd1) begin
                adr_q  <= hw_wdata[AW-1:0];
                wsel_q <= hw_wdata[AW+1:AW];
            end
        end
    end

    // Decode a command write with the write-direction select
    always_comb begin
        cmd_stb  = hw_en && (hw_sel == 2'd2) && !hw_wdata[RWS_BIT];
        cmd_kind = decode_op(hw_wdata[OP_LSB+3:OP_LSB]);
        cmd_code = hw_wdata[CW-1:0];
    end

endmodule

// File: rtl/sigch_cmd_unit.sv
// Command acceptance and the pending transfer held until frame boundary.
// Assumes commit is a single-cycle pulse at the last-timeslot edge.
module sigch_cmd_unit
    import sigch_pkg::*;
#(
    parameter int AW = 5,
    parameter int DW = 8,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_stb,
    input  xfer_kind_e    cmd_kind,
    input  logic [CW-1:0] cmd_code,
    input  logic [DW-1:0] stg_q,
    input  logic [AW-1:0] adr_q,
    input  logic [1:0]    wsel_q,
    input  logic          commit,
    output logic          busy,
    output logic          cmd_err,
    output logic          mem_we,
    output logic          mem_full,
    output logic [AW-1:0] mem_addr,
    output logic [CW-1:0] mem_code,
    output logic [DW-1:0] mem_data
);
    localparam logic [DW-1:0] ONES = '1;

    logic          valid_cmd;
    logic          accept;
    logic          reject;
    logic [DW-1:0] width_mask;
    logic [AW-1:0] pend_addr;
    logic [CW-1:0] pend_code;
    logic [DW-1:0] pend_data;
    logic          pend_full;

    // Classify the command against busy state and target parity
    always_comb begin
        valid_cmd = cmd_stb && (cmd_kind != XF_NONE) && !busy;
        accept    = valid_cmd && !adr_q[0];
        reject    = valid_cmd && adr_q[0];
    end

    // Build the right-aligned mask for the selected value width
    always_comb begin
        case (wsel_q)
            WSEL_4:  width_mask = ~(ONES << 4);
            WSEL_6:  width_mask = ~(ONES << 6);
            default: width_mask = ONES;
        endcase
    end

    // Capture the transfer operands at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_addr <= '0;
            pend_code <= '0;
            pend_data <= '0;
            pend_full <= 1'b0;
        end else if (accept) begin
            pend_addr <= adr_q;
            pend_code <= cmd_code;
            pend_data <= stg_q & width_mask;
            pend_full <= (cmd_kind == XF_FULL);
        end
    end

    // Hold busy from acceptance until the frame boundary commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
        end else if (accept) begin
            busy <= 1'b1;
        end else if (commit) begin
            busy <= 1'b0;
        end
    end

    // Record whether the last valid command was rejected
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_err <= 1'b0;
        end else if (accept) begin
            cmd_err <= 1'b0;
        end else if (reject) begin
            cmd_err <= 1'b1;
        end
    end

    // Present the pending transfer to the memory at commit
    always_comb begin
        mem_we   = busy && commit;
        mem_full = pend_full;
        mem_addr = pend_addr;
        mem_code = pend_code;
        mem_data = pend_data;
    end

endmodule

// File: rtl/sigch_cmem.sv
// Per-timeslot control memory: a code field and a data field per entry.
// Assumes one write port and one asynchronous read port.
module sigch_cmem #(
    parameter int N_TS = 32,
    parameter int AW   = 5,
    parameter int DW   = 8,
    parameter int CW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          we_full,
    input  logic [AW-1:0] waddr,
    input  logic [CW-1:0] wcode,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [CW-1:0] rcode,
    output logic [DW-1:0] rdata
);
    logic [CW-1:0] code_q [N_TS];
    logic [DW-1:0] data_q [N_TS];

    for (genvar i = 0; i < N_TS; i++) begin : g_entry
        // Update one entry when the commit targets it
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                code_q[i] <= '0;
                data_q[i] <= '0;
            end else if (we && (waddr == AW'(i))) begin
                data_q[i] <= wdata;
                if (we_full) begin
                    code_q[i] <= wcode;
                end
            end
        end
    end

    // Read the entry selected by the frame engine
    always_comb begin
        rcode = code_q[raddr];
        rdata = data_q[raddr];
    end

endmodule

// File: rtl/sigch_frame_tx.sv
// Frame engine: timeslot counter, commit pulse and per-slot output value.
// Assumes N_TS is even so every odd slot has an even partner.
module sigch_frame_tx #(
    parameter int              N_TS = 32,
    parameter int              AW   = 5,
    parameter int              DW   = 8,
    parameter int              CW   = 4,
    parameter logic [DW-1:0]   IDLE = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ts_tick,
    input  logic [CW-1:0] rcode,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] raddr,
    output logic [AW-1:0] ts_num,
    output logic          commit,
    output logic          tx_active,
    output logic [DW-1:0] tx_data
);
    localparam logic [AW-1:0] LAST = AW'(N_TS - 1);

    logic [AW-1:0] ts_cnt;

    // Step through the timeslots of the frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_cnt <= '0;
        end else if (ts_tick) begin
            ts_cnt <= (ts_cnt == LAST) ? '0 : ts_cnt + 1'b1;
        end
    end

    // Derive the boundary pulse and the sent value for this slot
    always_comb begin
        commit    = ts_tick && (ts_cnt == LAST);
        raddr     = {ts_cnt[AW-1:1], 1'b0};
        ts_num    = ts_cnt;
        tx_active = ts_cnt[0] && (rcode != '0);
        tx_data   = tx_active ? rdata : IDLE;
    end

endmodule

// File: rtl/sigch_ctrl_mem.sv
// Top level of the timeslot signaling channel memory controller.
// Assumes N_TS is even and DW >= 6; the host word is sized for the command.
module sigch_ctrl_mem
    import sigch_pkg::*;
#(
    parameter int            N_TS     = 32,
    parameter int            DW       = 8,
    parameter int            CW       = 4,
    parameter logic [DW-1:0] IDLE_VAL = '1,
    localparam int           AW       = $clog2(N_TS),
    localparam int           BUS_W    = ((DW > CW + 4) ? DW : CW + 4) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_en,
    input  logic [1:0]       hw_sel,
    input  logic [BUS_W-1:0] hw_wdata,
    input  logic             ts_tick,
    output logic [AW-1:0]    ts_num,
    output logic             tx_active,
    output logic [DW-1:0]    tx_data,
    output logic             busy,
    output logic             cmd_err
);
    logic [DW-1:0] stg_q;
    logic [AW-1:0] adr_q;
    logic [1:0]    wsel_q;
    logic          cmd_stb;
    xfer_kind_e    cmd_kind;
    logic [CW-1:0] cmd_code;
    logic          commit;
    logic          mem_we;
    logic          mem_full;
    logic [AW-1:0] mem_addr;
    logic [CW-1:0] mem_code;
    logic [DW-1:0] mem_data;
    logic [AW-1:0] raddr;
    logic [CW-1:0] rcode;
    logic [DW-1:0] rdata;

    sigch_host_regs #(.AW(AW), .DW(DW), .CW(CW), .BUS_W(BUS_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .hw_sel(hw_sel),
        .hw_wdata(hw_wdata), .stg_q(stg_q), .adr_q(adr_q), .wsel_q(wsel_q),
        .cmd_stb(cmd_stb), .cmd_kind(cmd_kind), .cmd_code(cmd_code)
    );

    sigch_cmd_unit #(.AW(AW), .DW(DW), .CW(CW)) u_cmd (
        .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_kind(cmd_kind),
        .cmd_code(cmd_code), .stg_q(stg_q), .adr_q(adr_q), .wsel_q(wsel_q),
        .commit(commit), .busy(busy), .cmd_err(cmd_err), .mem_we(mem_we),
        .mem_full(mem_full), .mem_addr(mem_addr), .mem_code(mem_code),
        .mem_data(mem_data)
    );

    sigch_cmem #(.N_TS(N_TS), .AW(AW), .DW(DW), .CW(CW)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .we_full(mem_full),
        .waddr(mem_addr), .wcode(mem_code), .wdata(mem_data),
        .raddr(raddr), .rcode(rcode), .rdata(rdata)
    );

    sigch_frame_tx #(.N_TS(N_TS), .AW(AW), .DW(DW), .CW(CW), .IDLE(IDLE_VAL)) u_frm (
        .clk(clk), .rst_n(rst_n), .ts_tick(ts_tick), .rcode(rcode),
        .rdata(rdata), .raddr(raddr), .ts_num(ts_num), .commit(commit),
        .tx_active(tx_active), .tx_data(tx_data)
    );

endmodule

// File: rtl/sigch_ctrl_mem_chk.sv
// Property checker for the signaling channel memory controller, bound to the top.
module sigch_ctrl_mem_chk #(
    parameter int            N_TS = 32,
    parameter int            AW   = 5,
    parameter int            DW   = 8,
    parameter logic [DW-1:0] IDLE = '1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ts_tick,
    input logic [AW-1:0] ts_num,
    input logic          tx_active,
    input logic [DW-1:0] tx_data,
    input logic          busy,
    input logic          cmd_err
);
    localparam logic [AW-1:0] LAST = AW'(N_TS - 1);

    logic past_ok;

    // Mark cycles whose previous sample lies after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_tick && ts_num != LAST) |=> (ts_num == $past(ts_num) + 1'b1)); // R2
    AST_TS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_tick && ts_num == LAST) |=> (ts_num == '0)); // R2
    AST_TS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ts_tick |=> $stable(ts_num)); // R2
    AST_EVEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ts_num[0] |-> (!tx_active && tx_data == IDLE)); // R3
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(ts_tick && ts_num == LAST)) |=> busy); // R9
    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ts_tick && ts_num == LAST) |=> !busy); // R9
    AST_NO_MIDFRAME_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $stable(ts_num)) |-> $stable(tx_data)); // R9
    AST_ERR_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(cmd_err)) |-> !$rose(busy)); // R11

endmodule

bind sigch_ctrl_mem sigch_ctrl_mem_chk #(
    .N_TS(N_TS), .AW(AW), .DW(DW), .IDLE(IDLE_VAL)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ts_tick(ts_tick), .ts_num(ts_num),
    .tx_active(tx_active), .tx_data(tx_data), .busy(busy), .cmd_err(cmd_err)
);

// File: tb/test_sigch_ctrl_mem.sv
module test_sigch_ctrl_mem;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_en = 1'b0;
    logic [1:0] hw_sel = 2'd0;
    logic [8:0] hw_wdata = '0;
    logic       ts_tick = 1'b0;
    logic [4:0] ts_num;
    logic       tx_active;
    logic [7:0] tx_data;
    logic       busy;
    logic       cmd_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model state
    int m_code [32];
    int m_data [32];
    int m_ts, m_busy, m_err, m_stg, m_adr, m_wsel;
    int p_addr, p_code, p_data, p_full;
    int nb, op;
    bit cmt;

    always #10 clk = ~clk;

    sigch_ctrl_mem i_sigch_ctrl_mem (
        .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .hw_sel(hw_sel),
        .hw_wdata(hw_wdata), .ts_tick(ts_tick), .ts_num(ts_num),
        .tx_active(tx_active), .tx_data(tx_data), .busy(busy), .cmd_err(cmd_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) begin
                m_code[i] = 0;
                m_data[i] = 0;
            end
            m_ts = 0; m_busy = 0; m_err = 0; m_stg = 0; m_adr = 0; m_wsel = 0;
            p_addr = 0; p_code = 0; p_data = 0; p_full = 0;
        end else begin
            cmt = ts_tick && (m_ts == 31);
            nb = m_busy;
            if (m_busy != 0 && cmt) begin
                m_data[p_addr] = p_data;
                if (p_full != 0) m_code[p_addr] = p_code;
                nb = 0;
            end
            if (hw_en) begin
                if (hw_sel == 2'd0) begin
                    m_stg = int'(hw_wdata[7:0]);
                end else if (hw_sel == 2'd1) begin
                    m_adr = int'(hw_wdata[4:0]);
                    m_wsel = int'(hw_wdata[6:5]);
                end else if (hw_sel == 2'd2 && !hw_wdata[8] && m_busy == 0) begin
                    op = int'(hw_wdata[7:4]);
                    if (op == 14 || op == 15 || op == 9) begin
                        if (m_adr % 2 == 1) begin
                            m_err = 1;
                        end else begin
                            m_err = 0;
                            nb = 1;
                            p_addr = m_adr;
                            p_code = int'(hw_wdata[3:0]);
                            p_full = (op != 9) ? 1 : 0;
                            p_data = m_stg & ((m_wsel == 0) ? 15 : (m_wsel == 1) ? 63 : 255);
                        end
                    end
                end
            end
            m_busy = nb;
            if (ts_tick) m_ts = (m_ts + 1) % 32;
        end
    end

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int ea, ed;
            ea = (m_ts % 2 == 1 && m_code[m_ts-1] != 0) ? 1 : 0;
            ed = (ea != 0) ? m_data[m_ts-1] : 255;
            chk("R2 ts_num model", 32'(ts_num), 32'(m_ts));
            chk("R3 tx_active model", 32'(tx_active), 32'(ea));
            chk("R3 tx_data model", 32'(tx_data), 32'(ed));
            chk("R9 busy model", 32'(busy), 32'(m_busy));
            chk("R11 cmd_err model", 32'(cmd_err), 32'(m_err));
        end
    end

    task automatic host_wr(input logic [1:0] sel, input logic [8:0] d);
        @(negedge clk);
        hw_en = 1'b1; hw_sel = sel; hw_wdata = d;
        @(negedge clk);
        hw_en = 1'b0;
    endtask

    function automatic logic [8:0] cmdw(input bit rws, input logic [3:0] o, input logic [3:0] c);
        return {rws, o, c};
    endfunction

    function automatic logic [8:0] adrw(input logic [1:0] w, input logic [4:0] a);
        return {2'b00, w, a};
    endfunction

    task automatic goto_ts(input int t);
        @(negedge clk);
        while (int'(ts_num) != t) begin
            ts_tick = 1'b1;
            @(negedge clk);
        end
        ts_tick = 1'b0;
    endtask

    task automatic run_frame();
        @(negedge clk);
        ts_tick = 1'b1;
        repeat (32) @(negedge clk);
        ts_tick = 1'b0;
    endtask

    task automatic summary();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R2 act=hung exp=finished");
        summary();
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 busy", 32'(busy), 0);
        chk("R1 cmd_err", 32'(cmd_err), 0);
        chk("R1 ts_num", 32'(ts_num), 0);
        goto_ts(1);
        chk("R1 idle odd slot", 32'(tx_data), 32'hFF);
        chk("R1 inactive", 32'(tx_active), 0);

        // R4 R5: full load of entry 4, width 8
        host_wr(2'd1, adrw(2'b10, 5'd4));
        host_wr(2'd0, 9'h0A5);
        host_wr(2'd2, cmdw(1'b0, 4'b1110, 4'd3));
        chk("R9 busy after command", 32'(busy), 1);
        goto_ts(5);
        chk("R9 not before boundary", 32'(tx_active), 0);
        run_frame();
        chk("R9 busy cleared", 32'(busy), 0);
        chk("R5 data sent", 32'(tx_data), 32'hA5);
        chk("R4 R5 active", 32'(tx_active), 1);

        // R6: data-only refresh keeps code
        host_wr(2'd0, 9'h03C);
        host_wr(2'd2, cmdw(1'b0, 4'b1001, 4'd0));
        run_frame();
        chk("R6 data refreshed", 32'(tx_data), 32'h3C);
        chk("R6 code kept", 32'(tx_active), 1);

        // R7: 4-bit width
        host_wr(2'd1, adrw(2'b00, 5'd4));
        host_wr(2'd0, 9'h0DB);
        host_wr(2'd2, cmdw(1'b0, 4'b1001, 4'd0));
        run_frame();
        chk("R7 width4", 32'(tx_data), 32'h0B);

        // R7 R5: 6-bit width, op 1111 (low bit ignored)
        host_wr(2'd1, adrw(2'b01, 5'd6));
        host_wr(2'd2, cmdw(1'b0, 4'b1111, 4'd1));
        goto_ts(7);
        run_frame();
        chk("R7 width6", 32'(tx_data), 32'h1B);
        chk("R5 op 1111 active", 32'(tx_active), 1);

        // R8: read select and unknown op ignored
        host_wr(2'd1, adrw(2'b10, 5'd4));
        host_wr(2'd0, 9'h077);
        host_wr(2'd2, cmdw(1'b1, 4'b1110, 4'd5));
        chk("R8 rws busy", 32'(busy), 0);
        host_wr(2'd2, cmdw(1'b0, 4'b0101, 4'd5));
        chk("R8 bad op busy", 32'(busy), 0);
        chk("R8 bad op err", 32'(cmd_err), 0);
        goto_ts(5);
        run_frame();
        chk("R8 entry unchanged", 32'(tx_data), 32'h0B);

        // R12: operands captured at command time
        host_wr(2'd1, adrw(2'b10, 5'd8));
        host_wr(2'd0, 9'h011);
        host_wr(2'd2, cmdw(1'b0, 4'b1110, 4'd2));
        host_wr(2'd0, 9'h022);
        host_wr(2'd1, adrw(2'b00, 5'd10));
        goto_ts(9);
        run_frame();
        chk("R12 captured data", 32'(tx_data), 32'h11);

        // R10: second command while busy ignored
        host_wr(2'd1, adrw(2'b10, 5'd12));
        host_wr(2'd0, 9'h044);
        host_wr(2'd2, cmdw(1'b0, 4'b1110, 4'd2));
        host_wr(2'd1, adrw(2'b10, 5'd10));
        host_wr(2'd0, 9'h033);
        host_wr(2'd2, cmdw(1'b0, 4'b1110, 4'd7));
        goto_ts(11);
        run_frame();
        chk("R10 ignored while busy", 32'(tx_active), 0);
        goto_ts(13);
        chk("R10 first command kept", 32'(tx_data), 32'h44);

        // R11: odd target rejected, then cleared by an accepted command
        host_wr(2'd1, adrw(2'b10, 5'd3));
        host_wr(2'd2, cmdw(1'b0, 4'b1001, 4'd0));
        chk("R11 err set", 32'(cmd_err), 1);
        chk("R11 not busy", 32'(busy), 0);
        host_wr(2'd1, adrw(2'b10, 5'd14));
        host_wr(2'd2, cmdw(1'b0, 4'b1110, 4'd1));
        chk("R11 err cleared", 32'(cmd_err), 0);
        run_frame();

        // R3: code 0 disables the pair
        host_wr(2'd1, adrw(2'b10, 5'd4));
        host_wr(2'd2, cmdw(1'b0, 4'b1110, 4'd0));
        goto_ts(5);
        run_frame();
        chk("R3 code zero idle", 32'(tx_data), 32'hFF);

        // R2: wrap
        goto_ts(31);
        @(negedge clk);
        ts_tick = 1'b1;
        @(negedge clk);
        ts_tick = 1'b0;
        chk("R2 wrap", 32'(ts_num), 0);

        // mixed traffic against the model
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            ts_tick = ($urandom % 4) != 0;
            hw_en = ($urandom % 3) == 0;
            hw_sel = 2'($urandom % 3);
            hw_wdata = 9'($urandom);
            if (hw_sel == 2'd2 && ($urandom % 2) == 0)
                hw_wdata[7:4] = ($urandom % 2 == 0) ? 4'b1001 : 4'b1110;
        end
        @(negedge clk);
        hw_en = 1'b0;
        ts_tick = 1'b0;
        @(negedge clk);
        summary();
        $finish;
    end

endmodule